// File: doc/BRIEF.md
# Sliding Window Maximum Filter

This block is a synchronous streaming filter for 12-bit unsigned samples. It captures one sample on every rising clock edge. It keeps the four most recent samples and drives out the largest of them. A typical use is as a peak-hold stage in a signal-processing path. There, a short burst should stay visible for a fixed number of samples and then drop out.

The history is a shift register. On each edge the new sample enters slot 0 and the oldest sample leaves. The maximum comes from a tree of two-input maximum cells. Each cell zero-extends its operands to 13 bits, subtracts them on a ripple-carry chain of full adders and lets the sign bit steer a 12-bit multiplexer. The comparison is done as x plus the inverted y plus a carry-in of one. The tree is combinational, with no pipelining. The result is captured in an output register.

Top module: `swmax_filter`

## Requirements
- R1: While `rst` is high at a rising edge, all four history slots and `max_out` are cleared to 0. The cleared slots then take part in the maximum as zeros until they are overwritten.
- R2: After the edge that captures sample s(n), the next edge sets `max_out` to the maximum of s(n), s(n-1), s(n-2) and s(n-3). A slot not yet written since reset counts as 0.
- R3: A sample stops affecting `max_out` once four newer samples have been captured. A single 4095 followed by zeros shows 4095 on exactly four consecutive outputs, then 0.
- R4: When the largest values in the window are equal, `max_out` equals that value.
- R5: Values are compared as unsigned numbers over the full range 0 to 4095. Values at or above 2048 always win against values below 2048.
- R6: Each two-input maximum cell outputs one of its two inputs, and that output is not smaller than either input.
- R7: Each subtractor produces the 13-bit value {0,x} minus {0,y} modulo 2^13. Its most significant bit is 1 exactly when x < y.
- R8: A new sample is accepted on every rising edge with no stall. Each output changes only on a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | 12 | Unsigned sample captured every rising edge |
| max_out | output | 12 | Registered maximum of the last four samples |

## Verification
The bench builds the filter with its default parameters: 12-bit samples and a window of four. This yields the three-cell tree of two pair cells feeding one final cell, and 13-bit subtractors. Those widths let random draws reach both ends of the range and the 2047/2048 boundary, where a sign-handling error in the subtractor would show. With a four-slot window, an isolated peak can be followed through its whole lifetime in a few cycles. Narrow-range random bursts create frequent ties between window entries.

// File: rtl/swmax_pkg.sv
package swmax_pkg;
  parameter int SAMPLE_W = 12;
  parameter int WINDOW   = 4;
  typedef logic [SAMPLE_W-1:0] sample_t;
endpackage

// File: rtl/rca_sub.sv
module rca_sub #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] diff
);
  logic [W:0]   carry;
  logic [W-1:0] y_inv;

  assign y_inv    = ~y;
  assign carry[0] = 1'b1;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_fa
      logic p;
      assign p          = x[i] ^ y_inv[i];
      assign diff[i]    = p ^ carry[i];
      assign carry[i+1] = (x[i] & y_inv[i]) | (carry[i] & p);
    end
  endgenerate

  // R7
  diff_value_chk: assert property (@(posedge clk) disable iff (rst)
    (diff == W'(x - y)) && (diff[W-1] == (x < y)));
endmodule

// File: rtl/max2.sv
module max2 #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam int EW = W + 1;

  logic [EW-1:0] a_ext;
  logic [EW-1:0] b_ext;
  logic [EW-1:0] delta;

  assign a_ext = {1'b0, a};
  assign b_ext = {1'b0, b};

  rca_sub #(.W(EW)) u_sub (
    .clk  (clk),
    .rst  (rst),
    .x    (a_ext),
    .y    (b_ext),
    .diff (delta)
  );

  assign y = delta[EW-1] ? b : a;

  // R6
  max_pick_chk: assert property (@(posedge clk) disable iff (rst)
    ((y == a) || (y == b)) && (y >= a) && (y >= b));
endmodule

// File: rtl/sample_history.sv
module sample_history #(
  parameter int W     = 12,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] taps [DEPTH]
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) taps[k] <= '0;
    end else begin
      taps[0] <= din;
      for (int k = 1; k < DEPTH; k++) taps[k] <= taps[k-1];
    end
  end

  // R8
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (taps[0] == $past(din)) && (taps[DEPTH-1] == $past(taps[DEPTH-2])));
endmodule

// File: rtl/max_tree.sv
module max_tree #(
  parameter int W      = 12,
  parameter int LEAVES = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] leaf [LEAVES],
  output logic [W-1:0] top
);
  localparam int NODES = 2 * LEAVES - 1;

  logic [W-1:0] node [NODES];

  genvar j, i;
  generate
    for (j = 0; j < LEAVES; j++) begin : g_leaf
      assign node[LEAVES-1+j] = leaf[j];
    end
    for (i = 0; i < LEAVES - 1; i++) begin : g_cell
      max2 #(.W(W)) u_max (
        .clk (clk),
        .rst (rst),
        .a   (node[2*i+1]),
        .b   (node[2*i+2]),
        .y   (node[i])
      );
    end
  endgenerate

  assign top = node[0];
endmodule

// File: rtl/swmax_filter.sv
module swmax_filter
  import swmax_pkg::*;
#(
  parameter int SW  = SAMPLE_W,
  parameter int WIN = WINDOW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] sample_in,
  output logic [SW-1:0] max_out
);
  logic [SW-1:0] hist [WIN];
  logic [SW-1:0] win_max;

  sample_history #(.W(SW), .DEPTH(WIN)) u_hist (
    .clk  (clk),
    .rst  (rst),
    .din  (sample_in),
    .taps (hist)
  );

  max_tree #(.W(SW), .LEAVES(WIN)) u_tree (
    .clk  (clk),
    .rst  (rst),
    .leaf (hist),
    .top  (win_max)
  );

  always_ff @(posedge clk) begin
    if (rst) max_out <= '0;
    else     max_out <= win_max;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (max_out == '0) && (hist[0] == '0) && (hist[WIN-1] == '0));

  genvar g;
  generate
    for (g = 0; g < WIN; g++) begin : g_chk
      // R2
      covers_slot_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (max_out >= $past(hist[g])));
    end
  endgenerate
endmodule

// File: tb/swmax_filter_test.sv
module swmax_filter_test;
  localparam int W = 12;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] sample_in = '0;
  logic [W-1:0] max_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [W-1:0] model [N];

  always #2 clk = ~clk;

  swmax_filter uut (
    .clk       (clk),
    .rst       (rst),
    .sample_in (sample_in),
    .max_out   (max_out)
  );

  function automatic logic [W-1:0] win_max();
    logic [W-1:0] m = '0;
    for (int k = 0; k < N; k++) if (model[k] > m) m = model[k];
    return m;
  endfunction

  task automatic check(input logic [W-1:0] exp, input string req);
    checks++;
    if (max_out !== exp) begin
      failures++;
      $display("FAIL %s: max_out=%0d expected=%0d", req, max_out, exp);
    end
  endtask

  task automatic step(input logic [W-1:0] v, input string req);
    logic [W-1:0] exp;
    sample_in = v;
    @(posedge clk);
    @(negedge clk);
    exp = win_max();
    check(exp, req);
    for (int k = N - 1; k > 0; k--) model[k] = model[k-1];
    model[0] = v;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    sample_in = 12'hFFF;
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < N; k++) model[k] = '0;
    check('0, "R1");
    rst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < N; k++) model[k] = '0;
    @(posedge clk);
    do_reset();
    // R1: cleared slots count as zero
    step(12'd0, "R1");
    step(12'd0, "R1");
    // R3: isolated peak lives four outputs
    step(12'd4095, "R3");
    for (int k = 0; k < 6; k++) step(12'd0, "R3");
    // R5: around the 2047/2048 boundary and range ends
    step(12'd2047, "R5");
    step(12'd2048, "R5");
    step(12'd2047, "R5");
    step(12'd0, "R5");
    step(12'd1, "R5");
    step(12'd4095, "R5");
    step(12'd4094, "R5");
    for (int k = 0; k < 5; k++) step(12'd2047, "R5");
    // R4: ties
    for (int k = 0; k < 6; k++) step(12'd777, "R4");
    step(12'd776, "R4");
    step(12'd777, "R4");
    // R2: descending and ascending ramps
    for (int k = 0; k < 8; k++) step(W'(4000 - k * 300), "R2");
    for (int k = 0; k < 8; k++) step(W'(k * 500), "R2");
    // R1: reset mid-stream
    do_reset();
    step(12'd5, "R1");
    step(12'd3, "R1");
    // R2 and R8: random full range every cycle
    for (int k = 0; k < 300; k++) step(W'($urandom), "R2");
    // R4: narrow-range random gives many ties
    for (int k = 0; k < 200; k++) step(W'(3000 + ($urandom % 4)), "R4");
    // R5: random values straddling the midpoint
    for (int k = 0; k < 200; k++) step(W'(2046 + ($urandom % 4)), "R5");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule